// File: doc/BRIEF.md
# Masked Address Breakpoint Comparator

This block watches every cycle the CPU places on the backplane bus and raises a halt request when the cycle matches one of a set of programmable breakpoints. Each breakpoint has a compare word and a mask word, and the host writes and reads both over a small register port. A mask bit of one brings the matching bit of the bus word into the comparison. A mask bit of zero leaves that bit out.

Every breakpoint runs two comparisons side by side. One is for read cycles and one is for write cycles. The read and write flag bits in the mask choose which of the two comparisons are armed. A single breakpoint can therefore trap reads only, writes only, or either kind of cycle, without needing both flags in the same bus cycle. DMA cycles are never compared. The bus word carries a physical address. The outputs of all breakpoints are ORed together and registered into a halt request that rises one clock after the matching cycle.

The bus word uses vector bit positions. Bits 35:22 carry the cycle flags: bit 35 user, 34 unused, 33 fetch, 32 read, 31 write-test, 30 write, 29 extended, 28 cache-enabled, 27 physical, 26 previous context, 25 IO, 24 IO who-are-you, 23 IO interrupt and 22 IO byte. Bits 21:0 carry the physical address.

Top module: `brk_watch`

## Requirements
- R1: After reset, every compare and mask register reads back as zero and haltReq is low.
- R2: The compare word of breakpoint k lives at byte offset 0x80+16k and its mask word at 0x88+16k, for k from 0 to 3. A cycle with hostWe high stores hostWdata[35:0] there. hostRdata shows the addressed register in the same cycle.
- R3: A write to any other offset, including offsets that are not multiples of 8, changes no register, and a read of such an offset returns zero.
- R4: Bits whose mask bit is 1 must be equal in the bus word and the compare word for a match. Bits whose mask bit is 0 never affect the result. The read flag (bit 32) and the write flag (bit 30) are never compared for equality.
- R5: The read path fires when mask bit 32 is set, bus bit 32 is set, and every other masked bit except bit 30 is equal.
- R6: The write path fires when mask bit 30 is set, bus bit 30 is set, and every other masked bit except bit 32 is equal.
- R7: With both mask bits 32 and 30 set, the breakpoint fires on a matching read cycle and also on a matching write cycle.
- R8: A breakpoint whose mask has neither bit 32 nor bit 30 set never fires. This includes an all-zero mask.
- R9: No match is made when busValid is low or when busDma is high.
- R10: haltReq is high in the clock cycle after a bus cycle that matches and low in all other cycles.
- R11: Each of the four breakpoints can raise haltReq on its own, whatever the other three hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 8 | Host register byte offset |
| hostWe | input | 1 | Host write strobe |
| hostWdata | input | 36 | Host write data |
| hostRdata | output | 36 | Readback of the addressed register, zero when unmapped |
| busValid | input | 1 | A bus cycle is present this clock |
| busWord | input | 36 | Cycle flags (35:22) and physical address (21:0) |
| busDma | input | 1 | The present cycle comes from DMA, not the CPU |
| haltReq | output | 1 | Halt request to the CPU |

## Verification
Directed cycles start from an exact hit on one breakpoint and then change one thing at a time. These cases are:
- a single masked address bit flipped, which must end the match;
- an unmasked flag flipped, which must not end it;
- a write cycle against a read-only breakpoint;
- a read cycle against a write-only breakpoint;
- DMA and idle cycles.

Together these separate the equality logic from the read and write path selection and from the qualification. Random register contents are paired with bus words built close to a programmed breakpoint. Random bits are placed only where the mask is zero, and the read and write flags are chosen at random. This exercises hit and miss outcomes in the same numbers across all four slots and shows whether the four results are ORed correctly. Writes to unmapped and misaligned offsets are followed by a full readback, which shows whether the address decode ever reaches a live register.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int BP_COUNT   = 4;
  localparam int WORD_W     = 36;
  localparam int HADDR_W    = 8;
  localparam int BP_BASE    = 'h80;
  localparam int SLOT_BYTES = 8;
  // vector positions of the two direction flags (flag n sits at WORD_W-1-n)
  localparam int RD_BIT     = WORD_W - 1 - 3;
  localparam int WR_BIT     = WORD_W - 1 - 5;
  localparam int SPAN_BYTES = BP_COUNT * 2 * SLOT_BYTES;

  typedef struct packed {
    logic [BP_COUNT-1:0] loadCmp;
    logic [BP_COUNT-1:0] loadMask;
    logic [BP_COUNT-1:0] selCmp;
    logic [BP_COUNT-1:0] selMask;
    logic                cpuCycle;
  } brk_strobe_t;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp
  import brk_pkg::*;
(
  input  logic [WORD_W-1:0] cmpWord,
  input  logic [WORD_W-1:0] cmpMask,
  input  logic [WORD_W-1:0] busWord,
  input  logic              qualify,
  output logic              readHit,
  output logic              writeHit
);
  localparam logic [WORD_W-1:0] DIR_BITS =
    (WORD_W'(1) << RD_BIT) | (WORD_W'(1) << WR_BIT);

  logic [WORD_W-1:0] diffBits;
  logic              bodyEqual;

  // direction flags act only as selectors, never as equality terms
  always_comb begin
    diffBits  = (busWord ^ cmpWord) & cmpMask & ~DIR_BITS;
    bodyEqual = (diffBits == '0);
    readHit   = qualify & cmpMask[RD_BIT] & busWord[RD_BIT] & bodyEqual;
    writeHit  = qualify & cmpMask[WR_BIT] & busWord[WR_BIT] & bodyEqual;
  end
endmodule

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  brk_strobe_t         strobe,
  input  logic [WORD_W-1:0]   hostWdata,
  input  logic [WORD_W-1:0]   busWord,
  output logic [WORD_W-1:0]   hostRdata,
  output logic [BP_COUNT-1:0] hitVec
);
  logic [WORD_W-1:0] cmpReg  [BP_COUNT];
  logic [WORD_W-1:0] maskReg [BP_COUNT];
  logic [BP_COUNT-1:0] rdHit, wrHit;

  for (genvar k = 0; k < BP_COUNT; k++) begin : g_bp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpReg[k]  <= '0;
        maskReg[k] <= '0;
      end else begin
        if (strobe.loadCmp[k])  cmpReg[k]  <= hostWdata;
        if (strobe.loadMask[k]) maskReg[k] <= hostWdata;
      end
    end

    brk_cmp u_cmp (
      .cmpWord  (cmpReg[k]),
      .cmpMask  (maskReg[k]),
      .busWord  (busWord),
      .qualify  (strobe.cpuCycle),
      .readHit  (rdHit[k]),
      .writeHit (wrHit[k])
    );

    assign hitVec[k] = rdHit[k] | wrHit[k];
  end

  always_comb begin
    hostRdata = '0;
    for (int k = 0; k < BP_COUNT; k++) begin
      if (strobe.selCmp[k])  hostRdata = hostRdata | cmpReg[k];
      if (strobe.selMask[k]) hostRdata = hostRdata | maskReg[k];
    end
  end
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [HADDR_W-1:0]  hostAddr,
  input  logic                hostWe,
  input  logic                busValid,
  input  logic                busDma,
  input  logic [BP_COUNT-1:0] hitVec,
  output brk_strobe_t         strobe,
  output logic                haltReq
);
  logic [HADDR_W-1:0] offset;
  logic [HADDR_W-1:0] pairIdx;
  logic               inRange;
  logic               aligned;

  always_comb begin
    offset  = hostAddr - HADDR_W'(BP_BASE);
    pairIdx = offset >> 4;
    inRange = (int'(hostAddr) >= BP_BASE) &&
              (int'(hostAddr) < BP_BASE + SPAN_BYTES);
    aligned = (offset[2:0] == 3'b000);
  end

  for (genvar k = 0; k < BP_COUNT; k++) begin : g_dec
    logic pairHit;
    assign pairHit            = inRange && aligned && (pairIdx == HADDR_W'(k));
    assign strobe.selCmp[k]   = pairHit && !offset[3];
    assign strobe.selMask[k]  = pairHit &&  offset[3];
    assign strobe.loadCmp[k]  = hostWe && strobe.selCmp[k];
    assign strobe.loadMask[k] = hostWe && strobe.selMask[k];
  end

  assign strobe.cpuCycle = busValid && !busDma;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) haltReq <= 1'b0;
    else       haltReq <= |hitVec;
  end
endmodule

// File: rtl/brk_watch.sv
module brk_watch
  import brk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic               hostWe,
  input  logic [WORD_W-1:0]  hostWdata,
  output logic [WORD_W-1:0]  hostRdata,
  input  logic               busValid,
  input  logic [WORD_W-1:0]  busWord,
  input  logic               busDma,
  output logic               haltReq
);
  brk_strobe_t         strobe;
  logic [BP_COUNT-1:0] hitVec;

  brk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostAddr (hostAddr),
    .hostWe   (hostWe),
    .busValid (busValid),
    .busDma   (busDma),
    .hitVec   (hitVec),
    .strobe   (strobe),
    .haltReq  (haltReq)
  );

  brk_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWdata (hostWdata),
    .busWord   (busWord),
    .hostRdata (hostRdata),
    .hitVec    (hitVec)
  );
endmodule

// File: rtl/brk_watch_chk.sv
module brk_watch_chk
  import brk_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                busValid,
  input logic                busDma,
  input logic [HADDR_W-1:0]  hostAddr,
  input logic [WORD_W-1:0]   hostRdata,
  input logic [BP_COUNT-1:0] hitVec,
  input logic                haltReq
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !haltReq);

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(hostAddr) < BP_BASE || int'(hostAddr) >= BP_BASE + SPAN_BYTES)
      |-> (hostRdata == '0));

  p_dma_blocked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busDma) |-> (hitVec == '0));

  p_idle_blocked_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (hitVec == '0));

  p_halt_on_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |=> haltReq);

  p_halt_only_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec == '0) |=> !haltReq);
endmodule

bind brk_watch brk_watch_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busDma    (busDma),
  .hostAddr  (hostAddr),
  .hostRdata (hostRdata),
  .hitVec    (hitVec),
  .haltReq   (haltReq)
);

// File: tb/brk_watch_tb_top.sv
`timescale 1ns/1ps
module brk_watch_tb_top;
  localparam int NBP = 4;
  localparam int RDB = 32;
  localparam int WRB = 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic        hostWe = 1'b0;
  logic [35:0] hostWdata = '0;
  logic [35:0] hostRdata;
  logic        busValid = 1'b0;
  logic [35:0] busWord = '0;
  logic        busDma = 1'b0;
  logic        haltReq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [35:0] shCmp  [NBP];
  logic [35:0] shMask [NBP];

  always #4 clk = ~clk;

  brk_watch dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .busValid(busValid),
    .busWord(busWord), .busDma(busDma), .haltReq(haltReq)
  );

  function automatic bit bpHit(logic [35:0] c, logic [35:0] m, logic [35:0] w);
    logic [35:0] body;
    body = ~((36'd1 << RDB) | (36'd1 << WRB));
    if (((w ^ c) & m & body) != 36'd0) return 0;
    return (m[RDB] && w[RDB]) || (m[WRB] && w[WRB]);
  endfunction

  function automatic bit expHalt(logic [35:0] w, bit dma, bit valid);
    bit h = 0;
    if (!valid || dma) return 0;
    for (int k = 0; k < NBP; k++) h |= bpHit(shCmp[k], shMask[k], w);
    return h;
  endfunction

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic [7:0] a, logic [35:0] d);
    @(negedge clk);
    busValid = 0;
    hostAddr = a; hostWdata = d; hostWe = 1;
    @(posedge clk);
    #1 hostWe = 0;
    if (a >= 8'h80 && a < 8'hC0 && a[2:0] == 3'b000) begin
      if (a[3]) shMask[(a - 8'h80) >> 4] = d;
      else      shCmp[(a - 8'h80) >> 4]  = d;
    end
  endtask

  task automatic hostRead(string req, logic [7:0] a, logic [35:0] exp);
    @(negedge clk);
    hostAddr = a;
    #1 check(req, hostRdata, exp);
  endtask

  task automatic busCycle(string req, logic [35:0] w, bit dma, bit valid);
    bit e;
    @(negedge clk);
    busWord = w; busDma = dma; busValid = valid;
    e = expHalt(w, dma, valid);
    @(posedge clk);
    #2 check(req, {35'd0, haltReq}, {35'd0, e});
  endtask

  task automatic readAll(string req);
    for (int k = 0; k < NBP; k++) begin
      hostRead(req, 8'(8'h80 + 16 * k), shCmp[k]);
      hostRead(req, 8'(8'h88 + 16 * k), shMask[k]);
    end
  endtask

  localparam logic [35:0] RD = 36'd1 << RDB;
  localparam logic [35:0] WR = 36'd1 << WRB;
  localparam logic [35:0] AMASK = 36'h0003FFFFF;

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [35:0] base;
    void'($urandom(32'd7341));
    for (int k = 0; k < NBP; k++) begin shCmp[k] = '0; shMask[k] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    check("R1 haltReq", {35'd0, haltReq}, 36'd0);
    readAll("R1 reset readback");

    // R2 write/readback of every register
    for (int k = 0; k < NBP; k++) begin
      hostWrite(8'(8'h80 + 16 * k), 36'h100000000 + 36'(k * 3 + 1));
      hostWrite(8'(8'h88 + 16 * k), 36'h0A5A5A5A0 + 36'(k));
    end
    readAll("R2 readback");

    // R3 unmapped and misaligned writes are ignored, reads zero
    hostWrite(8'h00, 36'hFFFFFFFFF);
    hostWrite(8'h84, 36'hFFFFFFFFF);
    hostWrite(8'h8C, 36'hFFFFFFFFF);
    hostWrite(8'hC0, 36'hFFFFFFFFF);
    hostWrite(8'h7F, 36'hFFFFFFFFF);
    readAll("R3 registers untouched");
    hostRead("R3 unmapped read", 8'hC0, 36'd0);
    hostRead("R3 misaligned read", 8'h84, 36'd0);
    hostRead("R3 low read", 8'h10, 36'd0);

    // clear all, then program breakpoint 0 as read-only on an address
    for (int k = 0; k < NBP; k++) begin
      hostWrite(8'(8'h80 + 16 * k), 36'd0);
      hostWrite(8'(8'h88 + 16 * k), 36'd0);
    end
    base = 36'h000123456 & AMASK;
    hostWrite(8'h80, base);
    hostWrite(8'h88, AMASK | RD);
    busCycle("R5 read hit", base | RD, 0, 1);
    busCycle("R10 halt drops", 36'd0, 0, 0);
    busCycle("R4 masked address bit differs", (base ^ 36'd4) | RD, 0, 1);
    busCycle("R4 unmasked user flag ignored", base | RD | (36'd1 << 35), 0, 1);
    busCycle("R5 write cycle on read-only", base | WR, 0, 1);
    busCycle("R9 dma ignored", base | RD, 1, 1);
    busCycle("R9 idle ignored", base | RD, 0, 0);

    // R6 write-only
    hostWrite(8'h88, AMASK | WR);
    busCycle("R6 write hit", base | WR, 0, 1);
    busCycle("R6 read cycle on write-only", base | RD, 0, 1);
    // R7 both directions
    hostWrite(8'h88, AMASK | WR | RD);
    busCycle("R7 read hit", base | RD, 0, 1);
    busCycle("R7 write hit", base | WR, 0, 1);
    // R4 a masked flag (fetch, bit 33) must match
    hostWrite(8'h88, AMASK | RD | (36'd1 << 33));
    busCycle("R4 masked flag mismatch", base | RD | (36'd1 << 33), 0, 1);
    busCycle("R4 masked flag match", base | RD, 0, 1);
    // R8 no direction bits
    hostWrite(8'h88, AMASK);
    busCycle("R8 no direction read", base | RD, 0, 1);
    busCycle("R8 no direction write", base | WR, 0, 1);
    hostWrite(8'h88, 36'd0);
    busCycle("R8 zero mask", 36'd0, 0, 1);
    busCycle("R8 zero mask rw", RD | WR, 0, 1);

    // R11 each slot alone
    for (int k = 0; k < NBP; k++) begin
      for (int j = 0; j < NBP; j++) hostWrite(8'(8'h88 + 16 * j), 36'd0);
      hostWrite(8'(8'h80 + 16 * k), 36'(16'h0100 + k));
      hostWrite(8'(8'h88 + 16 * k), AMASK | WR);
      busCycle("R11 single slot hit", 36'(16'h0100 + k) | WR, 0, 1);
      busCycle("R11 other address miss", 36'(16'h0200 + k) | WR, 0, 1);
    end

    // random phase
    for (int it = 0; it < 1200; it++) begin
      if (it % 60 == 0) begin
        for (int k = 0; k < NBP; k++) begin
          logic [35:0] m;
          m = {$urandom, $urandom} & {36{1'b1}};
          m = m | ({$urandom, $urandom} & 36'hFFFFFFFFF);
          m[RDB] = ($urandom % 3) != 0;
          m[WRB] = ($urandom % 3) != 0;
          hostWrite(8'(8'h80 + 16 * k), 36'({$urandom, $urandom}));
          hostWrite(8'(8'h88 + 16 * k), m);
        end
        readAll("R2 random readback");
      end
      begin
        int k;
        logic [35:0] w;
        k = int'($urandom % NBP);
        w = (shCmp[k] & shMask[k]) | (36'({$urandom, $urandom}) & ~shMask[k]);
        if ($urandom % 8 == 0) w = 36'({$urandom, $urandom});
        w[RDB] = $urandom % 2;
        w[WRB] = $urandom % 2;
        busCycle("R10 random cycle", w, ($urandom % 10) == 0, ($urandom % 8) != 0);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule